// File: doc/BRIEF.md
# Priority-Interleaved Runlist Builder

This block fills the runlist that a work dispatcher walks when it polls channels for pending commands. Software registers each channel in a table with a valid bit and a two-bit priority code. A start strobe triggers a build. The block then streams channel numbers into an external runlist memory, one entry per clock, so that urgent channels are revisited more often than relaxed ones.

Priority levels nest inside one another. A full pass over the most urgent level comes before every single slot of the level below it. That lower level advances by one channel, round robin, each time the pass above it completes. The same rule links the middle level to the lowest one. A level with no valid channel drops out of the nesting. The build ends once every channel of the lowest populated level has had its one slot. If the memory is too small for the list, the build stops at capacity and flags the overflow.

Top module: `rl_builder`

## Requirements
- R1: Priority code 2 or 3 marks a channel as urgent, code 1 as normal and code 0 as relaxed. A channel whose valid bit is 0 never appears in the list, whatever its code.
- R2: Inside a level, channels are taken in ascending channel number. Every channel of a more urgent level is written once before each single entry of the next less urgent level.
- R3: The slot after each urgent pass rotates through the next level's channels. The list ends right after the last channel of the lowest populated level has been written. Example: three urgent channels and one relaxed channel give the urgent three followed by the relaxed one.
- R4: A level with no valid channel is skipped. The next populated level then takes its slots directly under the remaining more urgent level. If only one level is populated, the list is its channels in order.
- R5: Exactly one entry is written per clock. `rl_we` first goes high one clock after the edge that samples `build_go`. Addresses run 0, 1, 2 and so on without gaps.
- R6: `build_done` is high for exactly one cycle, the cycle right after the last write. At that point `rl_len` equals the number of entries written, and it holds that value until the next build starts.
- R7: With no valid channel, nothing is written. `build_done` pulses two clocks after the edge that samples `build_go`, and `rl_len` reads 0.
- R8: When the list would exceed DEPTH entries, the build stops after DEPTH writes. `rl_len` then reads DEPTH and `build_ovf` is high from the done pulse until the next start. A list of exactly DEPTH entries does not raise `build_ovf`.
- R9: While a build is running, `build_go` and changes to the channel table have no effect on the list being built, and no second build follows.
- R10: After reset, `rl_we`, `build_done`, `build_ovf` and `rl_len` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_valid | input | NCH | Channel registered bit, one per channel |
| chan_prio | input | 2*NCH | Priority code of channel i in bits [2i+1:2i] |
| build_go | input | 1 | Start strobe, sampled while idle |
| rl_we | output | 1 | Runlist memory write enable |
| rl_addr | output | $clog2(DEPTH) | Runlist memory write address |
| rl_data | output | $clog2(NCH) | Channel number written |
| rl_len | output | $clog2(DEPTH+1) | Entries written by the current or last build |
| build_done | output | 1 | One-cycle end-of-build pulse |
| build_ovf | output | 1 | Last build was cut at memory capacity |

## Verification
The assertions watch the write stream on every cycle. They check that addresses start at zero and step by one, that writes happen only while the walker is busy, and that the done pulse lasts one cycle with no write beside it. They also check that the length never passes DEPTH and that an overflow reports exactly DEPTH. Some properties can only be shown by the bench's scenarios, because they depend on the whole table: the order of channel numbers in the list, dropping empty levels, the round-robin rotation of lower slots, the exact-fit and overflow boundaries, and ignoring a mid-build strobe.

// File: rtl/rl_pkg.sv
package rl_pkg;

  localparam int MAXCH = 64;
  localparam int IW    = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } walk_st_t;

  typedef enum logic [1:0] {
    CL_HI = 2'd0,
    CL_MD = 2'd1,
    CL_LO = 2'd2
  } prio_cl_t;

  // decode of the two-bit code: 2 and 3 urgent, 1 normal, 0 relaxed
  function automatic prio_cl_t code_to_class(input logic [1:0] code);
    if (code[1])      return CL_HI;
    else if (code[0]) return CL_MD;
    else              return CL_LO;
  endfunction

  // number of set bits in a mask
  function automatic logic [IW-1:0] mask_count(input logic [MAXCH-1:0] m);
    logic [IW-1:0] n;
    n = '0;
    for (int i = 0; i < MAXCH; i++) n = n + IW'(m[i]);
    return n;
  endfunction

  // lowest set bit at or above 'from'; 0 when none exists
  function automatic logic [IW-1:0] next_set(input logic [MAXCH-1:0] m,
                                             input logic [IW-1:0]    from);
    logic [IW-1:0] r;
    r = '0;
    for (int i = MAXCH - 1; i >= 0; i--)
      if (m[i] && (IW'(i) >= from)) r = IW'(i);
    return r;
  endfunction

endpackage

// File: rtl/rl_class_sort.sv
module rl_class_sort #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0]   valid_i,
  input  logic [2*NCH-1:0] prio_i,
  output logic [NCH-1:0]   hi_o,
  output logic [NCH-1:0]   md_o,
  output logic [NCH-1:0]   lo_o
);
  import rl_pkg::*;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    prio_cl_t cl;
    assign cl      = code_to_class(prio_i[2*g +: 2]);
    assign hi_o[g] = valid_i[g] && (cl == CL_HI);
    assign md_o[g] = valid_i[g] && (cl == CL_MD);
    assign lo_o[g] = valid_i[g] && (cl == CL_LO);
  end

endmodule

// File: rtl/rl_walk.sv
module rl_walk #(
  parameter int NCH   = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go_i,
  input  logic [NCH-1:0]             hi_i,
  input  logic [NCH-1:0]             md_i,
  input  logic [NCH-1:0]             lo_i,
  output logic                       we_o,
  output logic [$clog2(DEPTH)-1:0]   addr_o,
  output logic [$clog2(NCH)-1:0]     data_o,
  output logic [$clog2(DEPTH+1)-1:0] len_o,
  output logic                       done_o,
  output logic                       ovf_o,
  output logic                       busy_o
);
  import rl_pkg::*;

  localparam int CW = $clog2(NCH);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  walk_st_t        st;
  logic [NCH-1:0]  mh, mm, ml;
  logic [IW-1:0]   nh, nm, nl;
  logic [IW-1:0]   ph, pm, pl;
  logic [IW-1:0]   hp, mp, lp;
  logic [LW-1:0]   cnt;

  logic            take_h, take_m, take_l, take;
  logic            is_last, at_cap;
  logic [IW-1:0]   pick, first_h, first_m;

  assign first_h = next_set(MAXCH'(mh), '0);
  assign first_m = next_set(MAXCH'(mm), '0);

  always_comb begin
    take_h  = (st == ST_RUN) && (ph < nh);
    take_m  = (st == ST_RUN) && !(ph < nh) && (pm < nm);
    take_l  = (st == ST_RUN) && !(ph < nh) && !(pm < nm) && (pl < nl);
    take    = take_h || take_m || take_l;
    pick    = take_h ? hp : (take_m ? mp : lp);
    is_last = (take_l && ((pl + IW'(1)) == nl))
           || (take_m && (nl == '0) && ((pm + IW'(1)) == nm))
           || (take_h && (nl == '0) && (nm == '0) && ((ph + IW'(1)) == nh));
    at_cap  = (cnt == LW'(DEPTH - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mh     <= '0; mm <= '0; ml <= '0;
      nh     <= '0; nm <= '0; nl <= '0;
      ph     <= '0; pm <= '0; pl <= '0;
      hp     <= '0; mp <= '0; lp <= '0;
      cnt    <= '0;
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      done_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      we_o   <= 1'b0;
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (go_i) begin
          mh  <= hi_i; mm <= md_i; ml <= lo_i;
          nh  <= mask_count(MAXCH'(hi_i));
          nm  <= mask_count(MAXCH'(md_i));
          nl  <= mask_count(MAXCH'(lo_i));
          hp  <= next_set(MAXCH'(hi_i), '0);
          mp  <= next_set(MAXCH'(md_i), '0);
          lp  <= next_set(MAXCH'(lo_i), '0);
          ph  <= '0; pm <= '0; pl <= '0;
          cnt <= '0;
          ovf_o <= 1'b0;
          st  <= ST_RUN;
        end
        ST_RUN: begin
          if (!take) begin
            st <= ST_FIN;
          end else begin
            we_o   <= 1'b1;
            addr_o <= cnt[AW-1:0];
            data_o <= pick[CW-1:0];
            cnt    <= cnt + LW'(1);
            if (take_h) begin
              ph <= ph + IW'(1);
              hp <= next_set(MAXCH'(mh), hp + IW'(1));
            end else if (take_m) begin
              pm <= pm + IW'(1);
              mp <= next_set(MAXCH'(mm), mp + IW'(1));
              if ((pm + IW'(1)) < nm) begin
                ph <= '0;
                hp <= first_h;
              end
            end else begin
              pl <= pl + IW'(1);
              lp <= next_set(MAXCH'(ml), lp + IW'(1));
              pm <= '0; mp <= first_m;
              ph <= '0; hp <= first_h;
            end
            if (is_last) begin
              st <= ST_FIN;
            end else if (at_cap) begin
              ovf_o <= 1'b1;
              st    <= ST_FIN;
            end
          end
        end
        ST_FIN: begin
          done_o <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign len_o  = cnt;
  assign busy_o = (st != ST_IDLE);

endmodule

// File: rtl/rl_builder.sv
module rl_builder #(
  parameter int NCH   = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             chan_valid,
  input  logic [2*NCH-1:0]           chan_prio,
  input  logic                       build_go,
  output logic                       rl_we,
  output logic [$clog2(DEPTH)-1:0]   rl_addr,
  output logic [$clog2(NCH)-1:0]     rl_data,
  output logic [$clog2(DEPTH+1)-1:0] rl_len,
  output logic                       build_done,
  output logic                       build_ovf
);

  logic [NCH-1:0] cls_hi, cls_md, cls_lo;
  logic           walk_busy;

  rl_class_sort #(.NCH(NCH)) u_sort (
    .valid_i (chan_valid),
    .prio_i  (chan_prio),
    .hi_o    (cls_hi),
    .md_o    (cls_md),
    .lo_o    (cls_lo)
  );

  rl_walk #(.NCH(NCH), .DEPTH(DEPTH)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (build_go),
    .hi_i   (cls_hi),
    .md_i   (cls_md),
    .lo_i   (cls_lo),
    .we_o   (rl_we),
    .addr_o (rl_addr),
    .data_o (rl_data),
    .len_o  (rl_len),
    .done_o (build_done),
    .ovf_o  (build_ovf),
    .busy_o (walk_busy)
  );

endmodule

// File: rtl/rl_builder_chk.sv
module rl_builder_chk #(
  parameter int NCH   = 8,
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rl_we,
  input logic [$clog2(DEPTH)-1:0]   rl_addr,
  input logic [$clog2(DEPTH+1)-1:0] rl_len,
  input logic                       build_done,
  input logic                       build_ovf,
  input logic                       walk_busy
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rl_we && $past(rl_we) |-> rl_addr == ($past(rl_addr) + AW'(1)));

  p_first_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rl_we) |-> rl_addr == '0);

  p_write_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rl_we |-> walk_busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    build_done |=> !build_done);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    build_done |-> !rl_we && !walk_busy);

  p_len_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rl_len <= LW'(DEPTH));

  p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    build_done && build_ovf |-> rl_len == LW'(DEPTH));

endmodule

bind rl_builder rl_builder_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rl_we      (rl_we),
  .rl_addr    (rl_addr),
  .rl_len     (rl_len),
  .build_done (build_done),
  .build_ovf  (build_ovf),
  .walk_busy  (walk_busy)
);

// File: tb/rl_builder_test.sv
module rl_builder_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int DEPTH = 16;
  localparam int NVEC  = 7;

  // {valid, prio codes, expected length, expected overflow}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h0F, 16'h002A, 8'd4,  8'd0},  // three urgent, one relaxed
    {8'h7F, 16'h156E, 8'd16, 8'd0},  // urgent + normal, exact fit, code 3
    {8'h07, 16'h0818, 8'd3,  8'd0},  // one per level, invalid urgent ch5
    {8'hFF, 16'h056A, 8'd16, 8'd1},  // all levels, list of 26 cut at 16
    {8'h90, 16'h0000, 8'd2,  8'd0},  // relaxed only
    {8'h00, 16'hFFFF, 8'd0,  8'd0},  // nothing valid
    {8'h0F, 16'h0011, 8'd6,  8'd0}   // normal + relaxed, urgent missing
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  chan_valid = '0;
  logic [2*NCH-1:0] chan_prio = '0;
  logic            build_go = 1'b0;
  logic            rl_we;
  logic [$clog2(DEPTH)-1:0]   rl_addr;
  logic [$clog2(NCH)-1:0]     rl_data;
  logic [$clog2(DEPTH+1)-1:0] rl_len;
  logic            build_done;
  logic            build_ovf;

  int total = 0;
  int bad   = 0;
  int exp_seq [64];
  int exp_total;
  int got [64];
  int nwr, first_wr, last_wr, done_at, bad_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rl_builder #(.NCH(NCH), .DEPTH(DEPTH)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_valid (chan_valid),
    .chan_prio  (chan_prio),
    .build_go   (build_go),
    .rl_we      (rl_we),
    .rl_addr    (rl_addr),
    .rl_data    (rl_data),
    .rl_len     (rl_len),
    .build_done (build_done),
    .build_ovf  (build_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int ch);
    if (exp_total < 64) exp_seq[exp_total] = ch;
    exp_total++;
  endtask

  // independent model: group channels by level, then nest with loops
  task automatic model(input logic [7:0] v, input logic [15:0] p);
    int lv [3][8];
    int nlv [3];
    int pv [3][8];
    int pn [3];
    int np;
    nlv = '{0, 0, 0};
    pn  = '{0, 0, 0};
    for (int ch = 0; ch < 8; ch++) begin
      if (v[ch]) begin
        int k;
        k = (p[2*ch +: 2] >= 2) ? 0 : ((p[2*ch +: 2] == 1) ? 1 : 2);
        lv[k][nlv[k]] = ch;
        nlv[k]++;
      end
    end
    np = 0;
    for (int k = 0; k < 3; k++) begin
      if (nlv[k] > 0) begin
        for (int j = 0; j < nlv[k]; j++) pv[np][j] = lv[k][j];
        pn[np] = nlv[k];
        np++;
      end
    end
    exp_total = 0;
    if (np == 1) begin
      for (int a = 0; a < pn[0]; a++) push(pv[0][a]);
    end else if (np == 2) begin
      for (int y = 0; y < pn[1]; y++) begin
        for (int a = 0; a < pn[0]; a++) push(pv[0][a]);
        push(pv[1][y]);
      end
    end else if (np == 3) begin
      for (int z = 0; z < pn[2]; z++) begin
        for (int y = 0; y < pn[1]; y++) begin
          for (int a = 0; a < pn[0]; a++) push(pv[0][a]);
          push(pv[1][y]);
        end
        push(pv[2][z]);
      end
    end
  endtask

  // start a build and record the write stream, sampled at falling edges
  task automatic do_build(input logic [7:0] v, input logic [15:0] p, input bit poke);
    @(negedge clk);
    chan_valid = v; chan_prio = p; build_go = 1'b1;
    @(negedge clk);
    build_go = 1'b0;
    nwr = 0; first_wr = -1; last_wr = -1; done_at = -1; bad_addr = 0;
    for (int c = 0; c < 200; c++) begin
      if (rl_we) begin
        if (int'(rl_addr) != nwr) bad_addr++;
        if (nwr < 64) got[nwr] = int'(rl_data);
        if (first_wr < 0) first_wr = c;
        nwr++;
        last_wr = c;
      end
      if (build_done) begin
        done_at = c;
        break;
      end
      if (poke && c == 5) begin
        build_go = 1'b1; chan_valid = 8'h90; chan_prio = '0;
      end else begin
        build_go = 1'b0;
      end
      @(negedge clk);
    end
    build_go = 1'b0;
  endtask

  task automatic check_stream(input int vi, input int elen, input int eovf);
    int mism;
    mism = 0;
    for (int i = 0; i < elen; i++)
      if (i >= nwr || got[i] != exp_seq[i]) mism++;
    check(mism == 0, $sformatf("R2 R3 R4 order vec%0d", vi), mism, 0);
    check(nwr == elen && int'(rl_len) == elen, $sformatf("R6 R8 length vec%0d", vi), int'(rl_len), elen);
    check(int'(build_ovf) == eovf, $sformatf("R8 overflow vec%0d", vi), int'(build_ovf), eovf);
    check(bad_addr == 0, $sformatf("R5 address sequence vec%0d", vi), bad_addr, 0);
    if (elen > 0) begin
      check(first_wr == 1, $sformatf("R5 first write vec%0d", vi), first_wr, 1);
      check(done_at == last_wr + 1, $sformatf("R6 done after last write vec%0d", vi), done_at, last_wr + 1);
    end else begin
      check(done_at == 2, $sformatf("R7 empty done timing vec%0d", vi), done_at, 2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(rl_we == 1'b0, "R10 we in reset", int'(rl_we), 0);
    check(build_done == 1'b0, "R10 done in reset", int'(build_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(build_ovf == 1'b0, "R10 overflow after reset", int'(build_ovf), 0);
    check(rl_len == '0, "R10 length after reset", int'(rl_len), 0);

    for (int vi = 0; vi < NVEC; vi++) begin
      logic [7:0]  v;
      logic [15:0] p;
      int elen, eovf;
      v    = VEC[vi][39:32];
      p    = VEC[vi][31:16];
      elen = int'(VEC[vi][15:8]);
      eovf = int'(VEC[vi][7:0]);
      model(v, p);
      do_build(v, p, 1'b0);
      check_stream(vi, elen, eovf);
    end

    // R1: invalid urgent channel 5 in vec2 never written
    begin
      int hits;
      model(VEC[2][39:32], VEC[2][31:16]);
      do_build(VEC[2][39:32], VEC[2][31:16], 1'b0);
      hits = 0;
      for (int i = 0; i < nwr; i++) if (got[i] == 5) hits++;
      check(hits == 0, "R1 invalid channel absent", hits, 0);
    end

    // R9: strobe and table change mid-build are ignored
    model(VEC[3][39:32], VEC[3][31:16]);
    do_build(VEC[3][39:32], VEC[3][31:16], 1'b1);
    check_stream(3, 16, 1);
    begin
      int extra;
      extra = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (rl_we || build_done) extra++;
      end
      check(extra == 0, "R9 no second build", extra, 0);
    end

    // R6: length holds after done until next start
    check(int'(rl_len) == 16, "R6 length held", int'(rl_len), 16);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule